// File: doc/BRIEF.md
# SDRAM Mode-Register Load Issuer

This block gives software a single 32-bit register through which it programs the mode and extended-mode registers held inside the attached SDRAM devices while memory is being brought up. A write to the register stores three fields. The first is a two-bit bank selector. The second is a 12-bit load value for SDR and DDR parts. The third is a 14-bit load value for DDR2 parts. The same word also carries a command strobe bit, which is not stored.

When a write sets the strobe, the block drives one load command on the SDRAM command pins. The command goes to every chip select in the same cycle. The bank selector goes out on the bank pins, and the selector's value decides which internal register the devices load. The address pins carry either the 12-bit or the 14-bit value, depending on the DDR and DDR2 mode inputs.

After each command, a busy window with a programmable length keeps a second load from following too soon. A strobe written while the clock-enable control is clear is refused, and the block reports this on an error output.

Top module: `sdram_mrs_issuer`

## Requirements
- R1: After reset the read data is zero. In the same state, busy and error are low, every chip select is high, the RAS, CAS and WE pins are high, and the bank and address pins are zero.
- R2: A write accepted while mode_en=1 stores bits 31:30 as the bank selector, bits 29:18 as the 12-bit value and bits 13:0 as the 14-bit value. A read returns these fields in the same positions, with bits 17:14 (the strobe at bit 16 and the reserved bits) always read as zero.
- R3: While mode_en=0 a write has no effect. The read data does not change and no command is issued.
- R4: A write with bit 16 set, clock-enable set, the block not busy and a bank selector other than 11 issues exactly one load command. It appears in the cycle after the write's clock edge: all chip selects low, RAS, CAS and WE low, and the bank pins equal to the written selector. Selector 00 loads the mode register, 01 loads the extended register of standard DDR parts and 10 loads that of low-power DDR parts.
- R5: A strobe with bank selector 11 issues no command and does not start the busy window.
- R6: During a command, if both ddr_en and ddr2_en are set, the address pins carry the 14-bit value. Otherwise address bits 11:0 carry the 12-bit value and bits 13:12 are zero.
- R7: A strobe written while cke_en=0 issues no command. It raises err for exactly the following cycle.
- R8: busy rises with the command and stays high for max(mrd_cycles, 2) cycles. A strobe written while busy is high issues no command.
- R9: A write with bit 16 clear issues no command, but it still stores the fields.
- R10: In every cycle without a command, all chip selects and RAS, CAS and WE are high, and the bank and address pins are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| mode_en | input | 1 | Register write enable from controller setup |
| cke_en | input | 1 | SDRAM clock-enable is set |
| ddr_en | input | 1 | DDR mode selected |
| ddr2_en | input | 1 | DDR2 mode selected |
| mrd_cycles | input | 4 | Minimum gap after a load command, in cycles |
| sd_cs_n | output | 2 | Chip selects, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address pins |
| sd_a | output | 14 | Address pins |
| busy | output | 1 | Load window in progress |
| err | output | 1 | Strobe refused because clock-enable was clear |

## Verification
The bench sends random words with the strobe set often, across random settings of mode_en, cke_en, the two DDR mode inputs and the gap length. This mix separates the refusal causes from one another: clock-enable clear, bank selector 11, still busy, and the register locked. Directed cases cover the following:
- gap values 0 and 1, which must stretch to 2 cycles;
- a strobe placed in the last busy cycle and then in the first idle cycle;
- DDR set without DDR2, which tells the 12-bit path apart from the 14-bit path;
- all-ones data, which shows that the reserved bits and the strobe bit never read back.

// File: rtl/sdram_mrs_pkg.sv
package sdram_mrs_pkg;

    localparam int REG_W      = 32;
    localparam int BANK_LSB   = 30;
    localparam int STD_LSB    = 18;
    localparam int STD_W      = 12;
    localparam int WIDE_W     = 14;
    localparam int STROBE_BIT = 16;
    localparam int MIN_GAP    = 2;

    typedef enum logic [1:0] {
        BANK_MODE    = 2'b00,
        BANK_EXT_STD = 2'b01,
        BANK_EXT_LP  = 2'b10,
        BANK_RSVD    = 2'b11
    } bank_sel_e;

    typedef struct packed {
        bank_sel_e          bank;
        logic [STD_W-1:0]   addr_std;
        logic [WIDE_W-1:0]  addr_wide;
    } mrs_fields_t;

    function automatic mrs_fields_t unpack_word(input logic [REG_W-1:0] w);
        mrs_fields_t f;
        f.bank      = bank_sel_e'(w[BANK_LSB +: 2]);
        f.addr_std  = w[STD_LSB +: STD_W];
        f.addr_wide = w[0 +: WIDE_W];
        return f;
    endfunction

    function automatic logic [REG_W-1:0] pack_word(input mrs_fields_t f);
        logic [REG_W-1:0] w;
        w                   = '0;
        w[BANK_LSB +: 2]    = f.bank;
        w[STD_LSB +: STD_W] = f.addr_std;
        w[0 +: WIDE_W]      = f.addr_wide;
        return w;
    endfunction

endpackage

// File: rtl/sdram_mrs_regfile.sv
module sdram_mrs_regfile
    import sdram_mrs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata
);

    typedef struct packed {
        mrs_fields_t f;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.f = unpack_word(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = pack_word(st_q.f);

endmodule

// File: rtl/sdram_mrs_addr_mux.sv
module sdram_mrs_addr_mux #(
    parameter int STD_W  = 12,
    parameter int WIDE_W = 14
) (
    input  logic              wide_sel,
    input  logic [STD_W-1:0]  addr_std,
    input  logic [WIDE_W-1:0] addr_wide,
    output logic [WIDE_W-1:0] addr_out
);

    for (genvar i = 0; i < WIDE_W; i++) begin : g_bit
        if (i < STD_W) begin : g_shared
            assign addr_out[i] = wide_sel ? addr_wide[i] : addr_std[i];
        end else begin : g_wide_only
            assign addr_out[i] = wide_sel & addr_wide[i];
        end
    end

endmodule

// File: rtl/sdram_mrs_seq.sv
module sdram_mrs_seq
    import sdram_mrs_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int MRD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_wr,
    input  logic              cke_en,
    input  bank_sel_e         bank,
    input  logic [WIDE_W-1:0] addr_in,
    input  logic [MRD_W-1:0]  mrd_cycles,
    output logic [NUM_CS-1:0] cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [WIDE_W-1:0] a,
    output logic              busy,
    output logic              err
);

    localparam logic [MRD_W-1:0] GAP_FLOOR = MRD_W'(MIN_GAP);

    typedef struct packed {
        logic              cmd;
        logic [1:0]        ba;
        logic [WIDE_W-1:0] a;
        logic [MRD_W-1:0]  cnt;
        logic              err;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [MRD_W-1:0] gap_eff;

    always_comb begin
        gap_eff  = (mrd_cycles < GAP_FLOOR) ? GAP_FLOOR : mrd_cycles;
        st_d     = '0;
        st_d.cnt = (st_q.cnt != '0) ? st_q.cnt - 1'b1 : '0;
        if (strobe_wr) begin
            if (!cke_en) begin
                st_d.err = 1'b1;
            end else if (st_q.cnt == '0 && bank != BANK_RSVD) begin
                st_d.cmd = 1'b1;
                st_d.ba  = bank;
                st_d.a   = addr_in;
                st_d.cnt = gap_eff;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n  = {NUM_CS{~st_q.cmd}};
    assign ras_n = ~st_q.cmd;
    assign cas_n = ~st_q.cmd;
    assign we_n  = ~st_q.cmd;
    assign ba    = st_q.ba;
    assign a     = st_q.a;
    assign busy  = (st_q.cnt != '0);
    assign err   = st_q.err;

endmodule

// File: rtl/sdram_mrs_issuer.sv
module sdram_mrs_issuer
    import sdram_mrs_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int MRD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              mode_en,
    input  logic              cke_en,
    input  logic              ddr_en,
    input  logic              ddr2_en,
    input  logic [MRD_W-1:0]  mrd_cycles,
    output logic [NUM_CS-1:0] sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [1:0]        sd_ba,
    output logic [13:0]       sd_a,
    output logic              busy,
    output logic              err
);

    logic              wr_ok;
    logic              strobe_wr;
    mrs_fields_t       wr_fields;
    logic [WIDE_W-1:0] addr_sel;

    assign wr_ok     = reg_wr & mode_en;
    assign strobe_wr = wr_ok & reg_wdata[STROBE_BIT];
    assign wr_fields = unpack_word(reg_wdata);

    sdram_mrs_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_ok),
        .wdata (reg_wdata),
        .rdata (reg_rdata)
    );

    sdram_mrs_addr_mux #(
        .STD_W  (STD_W),
        .WIDE_W (WIDE_W)
    ) u_mux (
        .wide_sel  (ddr_en & ddr2_en),
        .addr_std  (wr_fields.addr_std),
        .addr_wide (wr_fields.addr_wide),
        .addr_out  (addr_sel)
    );

    sdram_mrs_seq #(
        .NUM_CS (NUM_CS),
        .MRD_W  (MRD_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_wr  (strobe_wr),
        .cke_en     (cke_en),
        .bank       (wr_fields.bank),
        .addr_in    (addr_sel),
        .mrd_cycles (mrd_cycles),
        .cs_n       (sd_cs_n),
        .ras_n      (sd_ras_n),
        .cas_n      (sd_cas_n),
        .we_n       (sd_we_n),
        .ba         (sd_ba),
        .a          (sd_a),
        .busy       (busy),
        .err        (err)
    );

endmodule

// File: rtl/sdram_mrs_checker.sv
module sdram_mrs_checker #(
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       reg_rdata,
    input logic              mode_en,
    input logic              cke_en,
    input logic              ddr_en,
    input logic              ddr2_en,
    input logic [NUM_CS-1:0] sd_cs_n,
    input logic              sd_ras_n,
    input logic [1:0]        sd_ba,
    input logic [13:0]       sd_a,
    input logic              busy,
    input logic              err
);

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[17:14] == 4'b0000); // R2

    AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> $stable(reg_rdata)); // R3

    AST_CS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cs_n == '0) || (sd_cs_n == '1)); // R4

    AST_SINGLE_CYCLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_ras_n |=> sd_ras_n); // R4

    AST_NO_RSVD_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_ras_n |-> sd_ba != 2'b11); // R5

    AST_NARROW_ADDR_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_ras_n && !($past(ddr_en) && $past(ddr2_en))) |-> sd_a[13:12] == 2'b00); // R6

    AST_NO_CMD_WO_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_ras_n |-> $past(cke_en)); // R7

    AST_ERR_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> sd_ras_n); // R7

    AST_BUSY_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_ras_n |-> busy); // R8

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        sd_ras_n |-> (sd_ba == 2'b00 && sd_a == 14'd0)); // R10

endmodule

bind sdram_mrs_issuer sdram_mrs_checker #(.NUM_CS(NUM_CS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .mode_en   (mode_en),
    .cke_en    (cke_en),
    .ddr_en    (ddr_en),
    .ddr2_en   (ddr2_en),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_ba     (sd_ba),
    .sd_a      (sd_a),
    .busy      (busy),
    .err       (err)
);

// File: tb/test_sdram_mrs_issuer.sv
`timescale 1ns/1ps
module test_sdram_mrs_issuer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mode_en = 1'b0;
    logic        cke_en = 1'b0;
    logic        ddr_en = 1'b0;
    logic        ddr2_en = 1'b0;
    logic [3:0]  mrd_cycles = '0;
    logic [1:0]  sd_cs_n;
    logic        sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [13:0] sd_a;
    logic        busy, err;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    logic [31:0] exp_rd = '0;
    bit done = 0;

    always #5 clk = ~clk;

    sdram_mrs_issuer i_sdram_mrs_issuer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mode_en(mode_en), .cke_en(cke_en),
        .ddr_en(ddr_en), .ddr2_en(ddr2_en), .mrd_cycles(mrd_cycles),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .busy(busy), .err(err)
    );

    function automatic logic [31:0] read_image(input logic [31:0] w);
        return {w[31:18], 4'b0000, w[13:0]};
    endfunction

    function automatic logic [13:0] addr_image(input logic [31:0] w, input logic wide);
        return wide ? w[13:0] : {2'b00, w[29:18]};
    endfunction

    function automatic int gap_of(input logic [3:0] m);
        return (m < 4'd2) ? 2 : int'(m);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle, then check every output against the model.
    task automatic step(input logic wr, input logic [31:0] data);
        logic  acc, e_err, wide;
        string why;
        @(negedge clk);
        reg_wr    = wr;
        reg_wdata = data;
        wide      = ddr_en & ddr2_en;
        acc   = wr && mode_en && data[16] && cke_en && (exp_cnt == 0) && (data[31:30] != 2'b11);
        e_err = wr && mode_en && data[16] && !cke_en;
        why = !wr ? "R10" : !mode_en ? "R3" : !data[16] ? "R9" : !cke_en ? "R7"
            : (exp_cnt != 0) ? "R8" : (data[31:30] == 2'b11) ? "R5" : "R4";
        @(posedge clk);
        #1;
        if (acc) exp_cnt = gap_of(mrd_cycles);
        else if (exp_cnt > 0) exp_cnt--;
        if (wr && mode_en) exp_rd = read_image(data);
        reg_wr = 1'b0;
        if (acc) begin
            check("R4 pins", {27'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'd0);
            check("R4 bank", {30'd0, sd_ba}, {30'd0, data[31:30]});
            check("R6 addr", {18'd0, sd_a}, {18'd0, addr_image(data, wide)});
        end else begin
            check({why, " no command"}, {27'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h1F);
            check("R10 idle ba/a", {16'd0, sd_ba, sd_a}, 32'd0);
        end
        check("R8 busy", {31'd0, busy}, {31'd0, exp_cnt != 0});
        check("R7 err", {31'd0, err}, {31'd0, e_err});
        check(wr && !mode_en ? "R3 read" : "R2 read", reg_rdata, exp_rd);
    endtask

    initial begin
        void'($urandom(32'h5D2A_11C7));
        repeat (3) @(posedge clk);
        #1;
        check("R1 rdata", reg_rdata, 32'd0);
        check("R1 pins", {27'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h1F);
        check("R1 busy/err/ba/a", {14'd0, busy, err, sd_ba, sd_a}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed: locked register.
        mode_en = 0; cke_en = 1;
        step(1, 32'h4005_0123);
        // Directed: all ones, R2 readback, reserved bank R5.
        mode_en = 1;
        step(1, 32'hFFFF_FFFF);
        // Directed: no strobe R9.
        step(1, 32'h8ABC_0055);
        // Directed: narrow address, ddr without ddr2 (R6), gap 0 -> 2.
        ddr_en = 1; ddr2_en = 0; mrd_cycles = 0;
        step(1, 32'h7FFD_3FFF);
        step(1, 32'h0001_0001);  // busy, ignored R8
        step(0, 0);
        step(1, 32'h8001_1234);  // first idle cycle, accepted
        // Wide address, gap 5, strobe in last busy cycle then after.
        ddr2_en = 1; mrd_cycles = 5;
        step(0, 0); step(0, 0);
        step(1, 32'h4001_2AAA);
        for (int k = 0; k < 4; k++) step(0, 0);
        step(1, 32'h0001_1555);  // last busy cycle: ignored
        step(1, 32'h0001_1555);  // now accepted
        // Clock-enable clear R7.
        cke_en = 0;
        repeat (6) step(0, 0);
        step(1, 32'h0001_0777);
        step(0, 0);

        // Random phase.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] w;
            mode_en    = ($urandom % 8) != 0;
            cke_en     = ($urandom % 6) != 0;
            ddr_en     = $urandom % 2;
            ddr2_en    = $urandom % 2;
            mrd_cycles = 4'($urandom % 7);
            w          = $urandom;
            if ($urandom % 3 != 0) w[16] = 1'b1;
            step(($urandom % 3) != 0, w);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(1_000_000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule